// File: doc/BRIEF.md
# Synchronous Burst SRAM with Single-Cycle Deselect

This block is a behavioural model of a synchronous burst static RAM with single-cycle deselect control. Every rising clock edge it samples three chip enables, two competing address strobes, an advance input and the write controls. It reduces them to one of four actions: deselect, start a burst, step a burst or hold a burst. A small internal array is organised as byte lanes, and each lane can be written on its own. The burst address generator keeps a two-bit beat counter. It walks four beats in either linear or interleaved order.

Read data comes out in one of two timings, chosen by a mode input. In flow-through timing the array output goes straight to the data port. In pipelined timing it goes through an extra register, so data appears one slot later. The data port is split into a read bus and a drive-enable bit; the drive-enable bit stands for the tri-state control of a bidirectional bus. An active-low output enable gates that drive bit combinationally.

Top module: `sync_burst_sram`

## Requirements
- R1: When the controller strobe `ctrl_strb_n` is low and the host strobe is not accepted, the cycle is a deselect if any enable is false (`cs_n` high, `cs_hi` low or `cs_lo_n` high). A deselect neither reads nor writes.
- R2: With `host_strb_n` low and `cs_n` low, the cycle starts a read burst at `addr` when `cs_hi`=1 and `cs_lo_n`=0, whatever the write inputs are. When either of those two enables is false, the cycle is a deselect. This host-strobe path takes priority over the controller strobe.
- R3: With the host strobe not accepted, `ctrl_strb_n` low and all enables true, the cycle starts a burst at `addr`. It is a write if a write is requested (see R6) and a read otherwise.
- R4: With both strobes high (or `host_strb_n` low while `cs_n` is high) and `ctrl_strb_n` high, `burst_adv_n`=0 steps to the next beat and `burst_adv_n`=1 repeats the current beat. Either action may read or write, and `cs_n` is ignored.
- R5: The beat order applies to address bits [1:0]. With `lin_order_n`=0, beat n uses (start+n) mod 4. With `lin_order_n`=1, beat n uses start XOR n. The fifth beat returns to the start, and bits above bit 1 keep the value loaded at burst start.
- R6: When `wr_all_n`=0, all four lanes are written. Otherwise, when `wr_byte_n`=0, exactly the lanes whose `lane_sel_n` bit is 0 are written (lane i is data bits [9i+8:9i]). Any other combination, including `wr_byte_n`=0 with `lane_sel_n`=4'b1111, is a read.
- R7: The output slot of a write cycle has `rdata_drv`=0 and `rdata`=0, whatever the lane selects are. A read slot drives all 36 bits.
- R8: With `bypass_n`=0 (flow-through), the data of a read accepted at edge k is presented after edge k. With `bypass_n`=1 (pipelined), it is presented after edge k+1.
- R9: `out_en_n`=1 forces `rdata_drv` to 0 in the same cycle, without waiting for a clock. Reads made while it is high still step the burst.
- R10: A deselect turns the drivers off in its own output slot: after edge k in flow-through, and after edge k+1 in pipelined timing.
- R11: A read on the cycle right after a write to the same address returns the newly written bytes.
- R12: While reset is asserted and until the first read slot, `rdata_drv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Primary chip select, active low |
| cs_hi | input | 1 | Secondary enable, active high |
| cs_lo_n | input | 1 | Secondary enable, active low |
| host_strb_n | input | 1 | Host address strobe, active low, always reads |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| burst_adv_n | input | 1 | Burst step request, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Lane-masked write, active low |
| lane_sel_n | input | 4 | Per-lane write select, active low |
| addr | input | 8 | External word address |
| wdata | input | 36 | Write data, four 9-bit lanes |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| bypass_n | input | 1 | 0 = flow-through, 1 = pipelined |
| lin_order_n | input | 1 | 0 = linear beat order, 1 = interleaved |
| rdata | output | 36 | Read data, zero when not driven |
| rdata_drv | output | 1 | Data bus drive enable |

## Verification
The properties assume that `bypass_n` changes only while the block is idle. For that reason each timing check also accepts the other mode's value in the sample where the mode differs. They also assume inputs are stable around the clock edge, since the decode is purely synchronous. The bench drives every input at the falling edge. It changes the timing mode only after at least two deselect cycles, so no read is still in flight. Output enable is changed only at the falling edge, and the combinational gating is sampled a moment after that change.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_START = 2'd1,
    ACT_NEXT  = 2'd2,
    ACT_HOLD  = 2'd3
  } sbs_act_e;

  // two-bit beat position from the start offset and the beat count
  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input logic       linear);
    return linear ? (start + beat) : (start ^ beat);
  endfunction
endpackage

// File: rtl/sbs_cmd_decode.sv
`timescale 1ns/1ps
module sbs_cmd_decode
  import sbs_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             cs_n,
  input  logic             cs_hi,
  input  logic             cs_lo_n,
  input  logic             host_strb_n,
  input  logic             ctrl_strb_n,
  input  logic             burst_adv_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_sel_n,
  output sbs_act_e         act,
  output logic             wr_act,
  output logic             rd_act,
  output logic [LANES-1:0] lane_wen
);
  localparam logic [LANES-1:0] NO_LANES = '1;

  logic             all_en;
  logic             wr_req;
  logic [LANES-1:0] lane_mask;

  always_comb begin
    all_en    = !cs_n && cs_hi && !cs_lo_n;
    wr_req    = !wr_all_n || (!wr_byte_n && (lane_sel_n != NO_LANES));
    lane_mask = !wr_all_n ? '1 : (!wr_byte_n ? ~lane_sel_n : '0);

    if (!host_strb_n && !cs_n) begin
      // host-strobed cycles only ever read
      act    = all_en ? ACT_START : ACT_IDLE;
      wr_act = 1'b0;
    end else if (!ctrl_strb_n) begin
      act    = all_en ? ACT_START : ACT_IDLE;
      wr_act = all_en && wr_req;
    end else begin
      act    = burst_adv_n ? ACT_HOLD : ACT_NEXT;
      wr_act = wr_req;
    end

    rd_act   = (act != ACT_IDLE) && !wr_act;
    lane_wen = wr_act ? lane_mask : '0;
  end
endmodule

// File: rtl/sbs_burst_addr.sv
`timescale 1ns/1ps
module sbs_burst_addr
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sbs_act_e          act,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lin_order_n,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] base_o,
  output logic [1:0]        beat_o
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        beat_q, beat_d;
  logic              ld_en;

  always_comb begin
    base_d = base_q;
    beat_d = beat_q;
    ld_en  = 1'b0;
    unique case (act)
      ACT_START: begin
        base_d = addr;
        beat_d = 2'd0;
        ld_en  = 1'b1;
      end
      ACT_NEXT: begin
        beat_d = beat_q + 2'd1;
        ld_en  = 1'b1;
      end
      default: ;
    endcase

    if (act == ACT_START) begin
      eff_addr = addr;
    end else begin
      eff_addr = {base_q[ADDR_W-1:2], beat_offset(base_q[1:0], beat_d, !lin_order_n)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (ld_en) begin
      base_q <= base_d;
      beat_q <= beat_d;
    end
  end

  assign base_o = base_q;
  assign beat_o = beat_q;
endmodule

// File: rtl/sbs_lane_array.sv
`timescale 1ns/1ps
module sbs_lane_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_wen,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_wen[g]) begin
        mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/sbs_out_stage.sv
`timescale 1ns/1ps
module sbs_out_stage #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_act,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic              bypass_n,
  input  logic              out_en_n,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_drv
);
  logic [ADDR_W-1:0] rd_addr_q;
  logic              rd_v_q;
  logic [DATA_W-1:0] pipe_q;
  logic              pipe_v_q;
  logic              slot_v;
  logic [DATA_W-1:0] slot_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
      rd_v_q    <= 1'b0;
      pipe_q    <= '0;
      pipe_v_q  <= 1'b0;
    end else begin
      rd_v_q   <= rd_act;
      pipe_v_q <= rd_v_q;
      if (rd_act) rd_addr_q <= eff_addr;
      if (rd_v_q) pipe_q    <= arr_rdata;
    end
  end

  always_comb begin
    slot_v    = bypass_n ? pipe_v_q : rd_v_q;
    slot_d    = bypass_n ? pipe_q : arr_rdata;
    rdata_drv = slot_v && !out_en_n;
    rdata     = rdata_drv ? slot_d : '0;
  end

  assign raddr = rd_addr_q;
endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    cs_hi,
  input  logic                    cs_lo_n,
  input  logic                    host_strb_n,
  input  logic                    ctrl_strb_n,
  input  logic                    burst_adv_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    out_en_n,
  input  logic                    bypass_n,
  input  logic                    lin_order_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_drv
);
  localparam int DATA_W = LANES * LANE_W;

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  sbs_act_e          act_w;
  logic              wr_w, rd_w;
  logic [LANES-1:0]  lane_wen_w, lane_wen_g;
  logic [ADDR_W-1:0] eff_addr_w, base_w, raddr_w;
  logic [1:0]        beat_w;
  logic [DATA_W-1:0] arr_rdata_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  sbs_cmd_decode #(.LANES(LANES)) dec_i (
    .cs_n(cs_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .host_strb_n(host_strb_n), .ctrl_strb_n(ctrl_strb_n),
    .burst_adv_n(burst_adv_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
    .lane_sel_n(lane_sel_n), .act(act_w), .wr_act(wr_w), .rd_act(rd_w),
    .lane_wen(lane_wen_w)
  );

  sbs_burst_addr #(.ADDR_W(ADDR_W)) bst_i (
    .clk(clk), .rst_n(rst_sync_n), .act(act_w), .addr(addr),
    .lin_order_n(lin_order_n), .eff_addr(eff_addr_w),
    .base_o(base_w), .beat_o(beat_w)
  );

  assign lane_wen_g = lane_wen_w & {LANES{rst_sync_n}};

  sbs_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) arr_i (
    .clk(clk), .lane_wen(lane_wen_g), .waddr(eff_addr_w), .wdata(wdata),
    .raddr(raddr_w), .rdata(arr_rdata_w)
  );

  sbs_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) out_i (
    .clk(clk), .rst_n(rst_sync_n), .rd_act(rd_w), .eff_addr(eff_addr_w),
    .bypass_n(bypass_n), .out_en_n(out_en_n), .arr_rdata(arr_rdata_w),
    .raddr(raddr_w), .rdata(rdata), .rdata_drv(rdata_drv)
  );
endmodule

// File: rtl/sbs_checker.sv
`timescale 1ns/1ps
module sbs_checker
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              host_strb_n,
  input logic              out_en_n,
  input logic              bypass_n,
  input logic [ADDR_W-1:0] addr,
  input sbs_act_e          act,
  input logic              wr_act,
  input logic              rd_act,
  input logic [ADDR_W-1:0] base_q,
  input logic [1:0]        beat_q,
  input logic              rdata_drv
);
  assert_host_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_strb_n && !cs_n) |-> !wr_act);

  assert_start_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_START) |=> (beat_q == 2'd0 && base_q == $past(addr)));

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_HOLD) |=> ($stable(beat_q) && $stable(base_q)));

  assert_step_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_NEXT) |=> (beat_q == $past(beat_q) + 2'd1 && $stable(base_q)));

  assert_wr_flow_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act && !bypass_n) |=> (bypass_n || !rdata_drv));

  assert_wr_pipe_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act && bypass_n) |=> ##1 (!bypass_n || !rdata_drv));

  assert_flow_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && !bypass_n && !out_en_n) |=> (bypass_n || out_en_n || rdata_drv));

  assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !rdata_drv);

  assert_desel_flow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_IDLE && !bypass_n) |=> (bypass_n || !rdata_drv));

  assert_desel_pipe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_IDLE && bypass_n) |=> ##1 (!bypass_n || !rdata_drv));
endmodule

bind sync_burst_sram sbs_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .cs_n(cs_n), .host_strb_n(host_strb_n),
  .out_en_n(out_en_n), .bypass_n(bypass_n), .addr(addr), .act(act_w),
  .wr_act(wr_w), .rd_act(rd_w), .base_q(base_w), .beat_q(beat_w),
  .rdata_drv(rdata_drv)
);

// File: tb/sync_burst_sram_tb_top.sv
`timescale 1ns/1ps
module sync_burst_sram_tb_top;
  localparam int AW = 8;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs_n, cs_hi, cs_lo_n, host_strb_n, ctrl_strb_n, burst_adv_n;
  logic          wr_all_n, wr_byte_n;
  logic [3:0]    lane_sel_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          out_en_n, bypass_n, lin_order_n;
  logic [DW-1:0] rdata;
  logic          rdata_drv;

  logic [DW-1:0] mirror [1 << AW];
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sync_burst_sram dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .host_strb_n(host_strb_n), .ctrl_strb_n(ctrl_strb_n), .burst_adv_n(burst_adv_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
    .addr(addr), .wdata(wdata), .out_en_n(out_en_n), .bypass_n(bypass_n),
    .lin_order_n(lin_order_n), .rdata(rdata), .rdata_drv(rdata_drv)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk_out(input logic exp_drv, input logic [DW-1:0] exp_d, input string req);
    n_chk++;
    if (rdata_drv !== exp_drv || (exp_drv && rdata !== exp_d) || (!exp_drv && rdata !== '0)) begin
      n_bad++;
      $display("FAIL %s drv=%b expected drv=%b data=%h expected data=%h",
               req, rdata_drv, exp_drv, rdata, exp_drv ? exp_d : '0);
    end
  endtask

  task automatic set_idle();
    cs_n = 1'b1; cs_hi = 1'b1; cs_lo_n = 1'b0;
    host_strb_n = 1'b1; ctrl_strb_n = 1'b0; burst_adv_n = 1'b1;
    wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_sel_n = 4'hF; wdata = '0;
  endtask

  // controller-strobed start; wr=1 writes all lanes
  task automatic set_start(input logic [AW-1:0] a, input bit wr, input logic [DW-1:0] d);
    set_idle();
    cs_n = 1'b0; addr = a; wdata = d; wr_all_n = !wr;
    if (wr) mirror[a] = d;
  endtask

  task automatic set_step(input bit hold, input bit wr, input logic [DW-1:0] d);
    set_idle();
    cs_n = 1'b1; ctrl_strb_n = 1'b1; burst_adv_n = hold; wr_all_n = !wr; wdata = d;
  endtask

  task automatic t_reset();
    chk_out(1'b0, '0, "R12 drive off after reset");
  endtask

  task automatic t_flow_basic();
    bypass_n = 1'b0; set_idle(); tick();
    set_start(8'h10, 1, 36'h1_2345_6789); tick();
    chk_out(1'b0, '0, "R7 write slot off");
    set_start(8'h10, 0, '0); tick();
    chk_out(1'b1, mirror[8'h10], "R11 read after write");
    set_idle(); tick();
    chk_out(1'b0, '0, "R10 flow deselect");
    chk_out(1'b0, '0, "R1 idle deselect");
  endtask

  task automatic t_pipe();
    set_idle(); bypass_n = 1'b1; tick(); tick();
    set_start(8'h10, 0, '0); tick();
    chk_out(1'b0, '0, "R8 pipe first slot empty");
    set_idle(); tick();
    chk_out(1'b1, mirror[8'h10], "R8 pipe data one slot later");
    tick();
    chk_out(1'b0, '0, "R10 pipe deselect");
    set_start(8'h10, 0, '0); tick();
    set_start(8'h50, 1, 36'hA_BCDE_F012); tick();
    chk_out(1'b1, mirror[8'h10], "R8 pipe read");
    set_start(8'h50, 0, '0); tick();
    chk_out(1'b0, '0, "R7 pipe write slot off");
    set_idle(); tick();
    chk_out(1'b1, mirror[8'h50], "R11 pipe read after write");
    tick(); tick();
    bypass_n = 1'b0; tick();
  endtask

  task automatic t_lanes();
    logic [DW-1:0] q;
    set_start(8'h20, 1, 36'h1_1111_1111); tick();
    q = 36'hF_0F0F_0F0F;
    set_idle(); cs_n = 1'b0; addr = 8'h20; wdata = q; wr_byte_n = 1'b0; lane_sel_n = 4'b1010;
    mirror[8'h20] = {mirror[8'h20][35:27], q[26:18], mirror[8'h20][17:9], q[8:0]};
    tick();
    chk_out(1'b0, '0, "R7 byte write slot off");
    set_idle(); cs_n = 1'b0; addr = 8'h21; wdata = 36'h5_A5A5_A5A5; wr_all_n = 1'b0;
    mirror[8'h21] = wdata;
    tick();
    chk_out(1'b0, '0, "R7 global write slot off");
    set_idle(); cs_n = 1'b0; addr = 8'h20; wdata = 36'hD_EADB_EEF0; wr_byte_n = 1'b0;
    tick();
    chk_out(1'b1, mirror[8'h20], "R6 no lane selected reads, lanes 0 and 2 merged");
    set_start(8'h21, 0, '0); tick();
    chk_out(1'b1, mirror[8'h21], "R6 global write ignores lane selects");
    set_idle(); tick();
  endtask

  task automatic t_host();
    set_idle(); host_strb_n = 1'b0; ctrl_strb_n = 1'b1; cs_n = 1'b0;
    addr = 8'h20; wr_all_n = 1'b0; wdata = 36'h0_0000_0BAD;
    tick();
    chk_out(1'b1, mirror[8'h20], "R2 host strobe reads despite write inputs");
    cs_hi = 1'b0; tick();
    chk_out(1'b0, '0, "R2 host strobe with enable false deselects");
    set_idle(); cs_n = 1'b0; cs_lo_n = 1'b1; addr = 8'h21; wr_all_n = 1'b0; wdata = 36'h0_0000_0BAD;
    tick();
    chk_out(1'b0, '0, "R1 controller strobe with enable false deselects");
    set_start(8'h20, 0, '0); tick();
    chk_out(1'b1, mirror[8'h20], "R2 memory kept after host strobe");
    set_start(8'h21, 0, '0); tick();
    chk_out(1'b1, mirror[8'h21], "R1 memory kept after deselect");
    set_idle(); tick();
  endtask

  task automatic t_burst();
    logic [AW-1:0] a;
    lin_order_n = 1'b0;
    set_start(8'h40, 1, 36'h0_0000_0040); tick();
    for (int i = 1; i < 4; i++) begin
      set_step(0, 1, 36'h0_0000_0040 + 36'(i));
      mirror[8'h40 + 8'(i)] = wdata;
      tick();
      chk_out(1'b0, '0, "R4 burst write step");
    end
    set_start(8'h42, 0, '0); tick();
    chk_out(1'b1, mirror[8'h42], "R3 burst start read");
    for (int i = 1; i < 5; i++) begin
      set_step(0, 0, '0); tick();
      a = {6'b010000, 2'(2 + i)};
      chk_out(1'b1, mirror[a], "R5 linear order and wrap, R4 cs_n ignored");
    end
    lin_order_n = 1'b1;
    set_start(8'h41, 0, '0); tick();
    chk_out(1'b1, mirror[8'h41], "R3 interleaved start");
    for (int i = 1; i < 4; i++) begin
      set_step(0, 0, '0); tick();
      a = {6'b010000, 2'(1 ^ i)};
      chk_out(1'b1, mirror[a], "R5 interleaved order");
    end
    set_step(1, 0, '0); tick();
    chk_out(1'b1, mirror[8'h42], "R4 hold repeats beat");
    set_idle(); tick();
    lin_order_n = 1'b0;
  endtask

  task automatic t_oe();
    out_en_n = 1'b1;
    set_start(8'h40, 0, '0); tick();
    chk_out(1'b0, '0, "R9 drive off with output enable high");
    set_step(0, 0, '0); tick();
    chk_out(1'b0, '0, "R9 drive off on step");
    out_en_n = 1'b0; #1;
    chk_out(1'b1, mirror[8'h41], "R9 gating at once and burst advanced");
    set_step(0, 0, '0); tick();
    chk_out(1'b1, mirror[8'h42], "R9 step after enable");
    set_idle(); tick();
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mirror[i] = '0;
    rst_n = 1'b0; out_en_n = 1'b0; bypass_n = 1'b0; lin_order_n = 1'b0; addr = '0;
    set_idle();
    repeat (3) tick();
    chk_out(1'b0, '0, "R12 drive off in reset");
    rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_flow_basic();
    t_pipe();
    t_lanes();
    t_host();
    t_burst();
    t_oe();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule